// File: doc/BRIEF.md
# Stereo ADC Serial Output Formatter

This block turns a stream of parallel stereo sample pairs into a single serial data line for a two-channel converter. A sample pair (one left word and one right word, each 20 bits in two's complement) is handed over with a one-cycle valid strobe. The pair is held and sent in the next frame, most significant bit first. Each channel takes a 32-bit-time slot with the data left-justified and zero padding after it. A left/right clock marks the channel, and a bit clock times each serial bit.

Everything runs from one master clock at 256 times the frame rate. The bit clock is the master clock divided by four, so a frame holds 64 bit times. In master mode the block starts its own frame and drives the left/right clock. In slave mode it waits for an edge on an external left/right clock and aligns its frame to that edge. An active-low digital power-down clears all state and forces the outputs low. In slave mode it also serves as the way to resynchronize.

Top module: `stereo_pcm_serializer`

## Requirements
- R1: In bit time i of a slot, where i runs from 0 to 19, `sdata` carries bit 19-i of that slot's sample, so the most significant bit goes first.
- R2: In bit times 20 to 31 of every slot, `sdata` is 0.
- R3: `lr_out` is 1 during the left slot and 0 during the right slot. `lr_oe` equals `master_en`.
- R4: `bclk` is low for two master clocks and then high for two master clocks in every bit time. `sdata` and `lr_out` change only on the master clock where `bclk` falls.
- R5: A frame is 256 master clocks: a left slot of 128 clocks followed by a right slot of 128 clocks.
- R6: A pair strobed with `smp_valid` is stored and sent from the next left slot start. A pair strobed on the very edge that starts a frame is sent in that frame.
- R7: If no new pair has arrived since the last frame start, the previous pair is sent again.
- R8: On the clock after an edge that sees `pd_n` low, `sdata`, `bclk` and `lr_out` are 0. The stored pairs are cleared, and strobes seen while `pd_n` is low have no effect.
- R9: In master mode, the frame starts with bit time 0 of the left slot on the first clock edge that sees `pd_n` high.
- R10: In slave mode, after `pd_n` rises the outputs stay low until `lr_in` changes. A rising edge starts the left slot, and a falling edge starts the right slot. Later `lr_in` edges have no effect until the next power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low digital power-down |
| master_en | input | 1 | 1 selects master mode, 0 selects slave mode |
| lr_in | input | 1 | External left/right clock, used in slave mode |
| smp_valid | input | 1 | One-cycle strobe that marks a new sample pair |
| smp_left | input | 20 | Left sample, two's complement |
| smp_right | input | 20 | Right sample, two's complement |
| sdata | output | 1 | Serial data |
| bclk | output | 1 | Bit clock |
| lr_out | output | 1 | Left/right clock, high for left |
| lr_oe | output | 1 | Drive enable for the left/right clock pin |

## Verification
The bench builds the block with its default parameters: 20-bit samples, 32-bit slots and a divide-by-four bit clock. At that size a frame is only 256 clocks, so several whole frames can be compared clock by clock against an arithmetic model. That covers every bit time of both slots and every phase of the bit clock. The same run reaches the corner cases: a pair strobed on the frame-start edge, frames that repeat an old pair, power-down in the middle of a frame, and slave alignment on both a rising and a falling `lr_in` edge.

// File: rtl/stereo_pcm_serializer.sv
module stereo_pcm_serializer #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  parameter int DIV_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pd_n,
  input  logic                master_en,
  input  logic                lr_in,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                sdata,
  output logic                bclk,
  output logic                lr_out,
  output logic                lr_oe
);

  localparam int SLOT_LOG2 = $clog2(SLOT_W);
  localparam int CNT_W     = DIV_LOG2 + SLOT_LOG2 + 1;
  localparam logic [CNT_W-1:0] FRAME_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0]    cnt;
  logic                run;
  logic                lr_q;
  logic [SAMPLE_W-1:0] pend_l, pend_r, hold_l, hold_r;

  wire lr_edge = lr_in ^ lr_q;
  wire start_m = !run && master_en;
  wire start_s = !run && !master_en && lr_edge;
  wire wrap    = run && (cnt == FRAME_LAST);
  wire load    = start_m || start_s || wrap;

  wire [SAMPLE_W-1:0] nxt_l = smp_valid ? smp_left  : pend_l;
  wire [SAMPLE_W-1:0] nxt_r = smp_valid ? smp_right : pend_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      run    <= 1'b0;
      lr_q   <= 1'b0;
      pend_l <= '0;
      pend_r <= '0;
      hold_l <= '0;
      hold_r <= '0;
    end else begin
      lr_q <= lr_in;
      if (!pd_n) begin
        cnt    <= '0;
        run    <= 1'b0;
        pend_l <= '0;
        pend_r <= '0;
        hold_l <= '0;
        hold_r <= '0;
      end else begin
        if (smp_valid) begin
          pend_l <= smp_left;
          pend_r <= smp_right;
        end
        if (load) begin
          hold_l <= nxt_l;
          hold_r <= nxt_r;
        end
        if (start_m) begin
          run <= 1'b1;
          cnt <= '0;
        end else if (start_s) begin
          run <= 1'b1;
          cnt <= {~lr_in, {(CNT_W-1){1'b0}}};
        end else if (run) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  wire [SLOT_LOG2-1:0] bitpos = cnt[CNT_W-2:DIV_LOG2];
  wire                 slot_r = cnt[CNT_W-1];
  wire [SAMPLE_W-1:0]  word   = slot_r ? hold_r : hold_l;
  wire [SAMPLE_W-1:0]  shl    = word << bitpos;

  assign sdata  = run & shl[SAMPLE_W-1];
  assign bclk   = run & cnt[DIV_LOG2-1];
  assign lr_out = run & ~slot_r;
  assign lr_oe  = master_en;

  a_r8_powerdown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!sdata && !bclk && !lr_out));

  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && int'(bitpos) >= SAMPLE_W) |-> !sdata);

  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(sdata)) |-> $fell(bclk));

  a_r4_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(lr_out)) |-> $fell(bclk));

  a_r9_master_left_first: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && $rose(run)) |-> (lr_out && !bclk));

  a_r10_slave_align: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && $rose(run)) |-> (lr_out == $past(lr_in)));

endmodule

// File: tb/test_stereo_pcm_serializer.sv
module test_stereo_pcm_serializer;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rst_n, pd_n, master_en, lr_in, smp_valid;
  logic [SW-1:0] smp_left, smp_right;
  logic sdata, bclk, lr_out, lr_oe;

  int checks = 0;
  int errors = 0;

  logic          m_run, m_lrq, m_fresh, m_pnew;
  int            m_cnt;
  logic [SW-1:0] m_pl, m_pr, m_hl, m_hr;

  always #10 clk = ~clk;

  stereo_pcm_serializer i_stereo_pcm_serializer (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .master_en(master_en),
    .lr_in(lr_in), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .sdata(sdata), .bclk(bclk), .lr_out(lr_out),
    .lr_oe(lr_oe));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic start, load;
    int   nc;
    start = 1'b0;
    nc    = 0;
    if (!pd_n) begin
      m_run = 0; m_cnt = 0; m_pl = '0; m_pr = '0; m_hl = '0; m_hr = '0;
      m_pnew = 0; m_fresh = 0;
    end else begin
      if (!m_run && master_en) begin start = 1; nc = 0; end
      else if (!m_run && !master_en && lr_in != m_lrq) begin
        start = 1; nc = lr_in ? 0 : 128;
      end
      load = start || (m_run && m_cnt == 255);
      if (load) begin
        m_hl = smp_valid ? smp_left  : m_pl;
        m_hr = smp_valid ? smp_right : m_pr;
        m_fresh = smp_valid || m_pnew;
        m_pnew = 0;
      end
      if (smp_valid) begin
        m_pl = smp_left; m_pr = smp_right;
        if (!load) m_pnew = 1;
      end
      if (start) begin m_run = 1; m_cnt = nc; end
      else if (m_run) m_cnt = (m_cnt + 1) % 256;
    end
    m_lrq = lr_in;
  endtask

  task automatic compare();
    int bp;
    logic slot;
    logic [SW-1:0] w;
    check("R3 lr_oe", lr_oe, master_en);
    if (!m_run) begin
      string t;
      t = !pd_n ? "R8 idle" : "R10 idle";
      check(t, sdata, 1'b0);
      check(t, bclk, 1'b0);
      check(t, lr_out, 1'b0);
    end else begin
      slot = (m_cnt >= 128);
      bp   = (m_cnt % 128) / 4;
      w    = slot ? m_hr : m_hl;
      check("R3 R5 lr", lr_out, !slot);
      check("R4 bclk", bclk, (m_cnt % 4) >= 2);
      if (bp < SW) check(m_fresh ? "R1 R6 data" : "R1 R7 data", sdata, w[SW-1-bp]);
      else         check("R2 pad", sdata, 1'b0);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      #1;
      compare();
      smp_valid = 1'b0;
    end
  endtask

  task automatic give(input logic [SW-1:0] l, input logic [SW-1:0] r);
    smp_left = l; smp_right = r; smp_valid = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pd_n = 0; master_en = 1; lr_in = 0; smp_valid = 0;
    smp_left = '0; smp_right = '0;
    m_run = 0; m_lrq = 0; m_fresh = 0; m_pnew = 0; m_cnt = 0;
    m_pl = '0; m_pr = '0; m_hl = '0; m_hr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R8 reset sdata", sdata, 1'b0);
    check("R8 reset bclk", bclk, 1'b0);
    check("R8 reset lr", lr_out, 1'b0);
    check("R3 reset lr_oe", lr_oe, 1'b1);
    step(3);

    // master start with a pair strobed on the starting edge
    give(20'h80001, 20'h7FFFE);
    pd_n = 1;
    step(1);
    check("R9 first left", lr_out, 1'b1);
    check("R9 first bclk", bclk, 1'b0);
    check("R9 first msb", sdata, 1'b1);
    step(100);
    give(20'hA5A5A, 20'h5A5A5);
    step(400);
    while (m_cnt != 255) step(1);
    give(20'hFFFFF, 20'h00000);
    step(300);
    give(20'h00001, 20'h80000);
    step(60);

    // power-down mid frame, strobe during it must be ignored
    pd_n = 0;
    step(2);
    give(20'h12345, 20'h6789A);
    step(3);
    pd_n = 1;
    step(300);

    // slave, rising-edge alignment
    pd_n = 0; master_en = 0; lr_in = 0;
    step(3);
    pd_n = 1;
    give(20'h3C3C3, 20'hC3C3C);
    step(20);
    lr_in = 1;
    step(1);
    check("R10 rise left", lr_out, 1'b1);
    check("R10 rise msb", sdata, 1'b0);
    step(50);
    for (int k = 0; k < 6; k++) begin
      lr_in = ~lr_in;
      step(37 + 11 * k);
    end
    step(200);

    // slave, falling-edge alignment
    pd_n = 0; lr_in = 1;
    step(3);
    pd_n = 1;
    step(2);
    give(20'h40000, 20'hBFFFF);
    step(5);
    lr_in = 0;
    step(1);
    check("R10 fall right", lr_out, 1'b0);
    check("R10 fall msb", sdata, 1'b1);
    step(300);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule